// File: doc/BRIEF.md
# Reference Clock Monitor and Selector

This block watches four reference clocks, each sampled against a fast local system clock, and chooses which of them should drive the downstream timing loop. For every reference it measures the gap between rising edges and counts edges over a shared gate window. From these measurements it decides whether the reference is serviceable. Among the serviceable references it picks the one with the best programmed priority and reports the choice as an index with a valid flag. A one-cycle pulse marks each change of choice.

Activity is judged on two scales. A gap longer than a short limit is one short interruption. Short interruptions are added to a leaky bucket, which loses one count at every gate-window boundary. A single isolated short interruption is therefore forgiven, while a burst of them fails the reference. A gap longer than a second, larger limit fails the reference at once. Frequency is judged once per gate window: the edge count must lie within a nominal count plus or minus a tolerance. This check can be switched off by a control input.

A failed reference stays out of selection until it has passed both checks for a programmed number of consecutive clean gate windows. Out of reset every reference counts as failed. All control and status pins are plain levels. There is no data stream and no handshake.

Top module: `refclk_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ref_ok` is 0000, `sel_valid` is 0 and `switch_pulse` is 0.
- R2: A failed reference becomes serviceable (`ref_ok[i]`=1) only at a gate-window end, after `restore_wins` consecutive clean windows. A window is clean when it had no short interruption, no long gap and, when the frequency check is on, an edge count within NOM_EDGES±TOL_EDGES.
- R3: When a window's edge count (rising edges of input i, synchronised) is outside NOM_EDGES±TOL_EDGES, `ref_freq_alarm[i]` is 1 from the cycle after that window's end. With `freq_chk_en`=1 the reference then fails in the following cycle.
- R4: With `freq_chk_en`=0 an out-of-range count never fails a reference and never prevents restoration. `ref_freq_alarm` still reports the raw measurement.
- R5: A gap between rising edges that reaches `short_lim` cycles but stays below `long_lim` counts as one short interruption. With `bucket_thr`≥2, one such interruption neither fails the reference nor changes the selection.
- R6: When a reference's current gap reaches `long_lim` cycles, `ref_gap_alarm[i]` rises and `ref_ok[i]` is 0 from the next cycle.
- R7: Each short interruption adds one to the reference's bucket, and each gate-window end removes one (never below zero). A bucket at or above `bucket_thr` raises `ref_gap_alarm[i]` and fails the reference.
- R8: The selection is the serviceable reference with the smallest nonzero priority. The 4-bit field `ref_pri[4*i+3:4*i]` holds the priority of input i, and priority 0 disables that input. On equal priority the lower index wins. When no reference qualifies, `sel_valid` is 0 and `sel_idx` is 0. The registered selection lags its inputs by one cycle.
- R9: `switch_pulse` is high for exactly the cycles in which the registered selection (valid flag or, when valid, index) differs from its previous value.
- R10: A failed reference is never the selection. Once restored it competes again, and a better-priority restored reference takes the selection back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 4 | The four reference clocks, asynchronous to clk |
| ref_pri | input | 4*PRI_W | Priority per input, field i at [PRI_W*i +: PRI_W]; 0 disables |
| freq_chk_en | input | 1 | 1 enables rejection on out-of-range frequency |
| short_lim | input | GAP_W | Gap length (clk cycles) counting as a short interruption |
| long_lim | input | GAP_W | Gap length (clk cycles) failing a reference at once |
| bucket_thr | input | BKT_W | Bucket level at which short interruptions fail a reference |
| restore_wins | input | WIN_W | Consecutive clean windows required to restore a reference |
| sel_idx | output | 2 | Index of the selected reference |
| sel_valid | output | 1 | A serviceable, enabled reference is selected |
| switch_pulse | output | 1 | One-cycle pulse on each change of selection |
| ref_ok | output | 4 | Per-input serviceable flag |
| ref_gap_alarm | output | 4 | Per-input long-gap or full-bucket alarm |
| ref_freq_alarm | output | 4 | Per-input raw out-of-range result of the last window |

## Verification
The bench builds the block with a 64-cycle gate window, a nominal count of 8 edges and a tolerance of 2. Its reference clocks toggle every 4 system cycles. With this setup, bucket leakage, two-window restoration and frequency rejection all play out within a few hundred cycles. Short limit 12, long limit 40, bucket threshold 2 and restore count 2 let a 6-cycle freeze act as one forgiven short gap, three such freezes act as a bucket failure, and a 50-cycle freeze act as a long gap. A reference switched to a 4-cycle period is clearly out of the frequency window.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int REF_COUNT = 4;
  localparam int REF_IDX_W = $clog2(REF_COUNT);

  typedef struct packed {
    logic                 valid;
    logic [REF_IDX_W-1:0] idx;
  } pick_t;
endpackage

// File: rtl/refsel_lane.sv
// Per-input activity monitor: synchroniser, edge detect, gap timer and
// leaky bucket of short interruptions.
module refsel_lane #(
  parameter int GAP_W = 16,
  parameter int BKT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_raw,
  input  logic             gate_end,
  input  logic [GAP_W-1:0] short_lim,
  input  logic [GAP_W-1:0] long_lim,
  input  logic [BKT_W-1:0] bucket_thr,
  output logic             edge_p,
  output logic             act_alarm,
  output logic             act_clean
);
  localparam logic [GAP_W:0] GAP_ONE = (GAP_W+1)'(1);

  logic             s1, s2, s3;
  logic [GAP_W-1:0] gap;
  logic [BKT_W-1:0] bucket;
  logic             win_dirty;
  logic             short_ev, long_lv, bkt_inc, bkt_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ref_raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_p = s2 & ~s3;

  // gap timer, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap <= '0;
    else if (edge_p)        gap <= '0;
    else if (gap != '1)     gap <= gap + GAP_W'(1);
  end

  // one short event per gap, in the cycle the timer reaches the limit
  assign short_ev = !edge_p && (({1'b0, gap} + GAP_ONE) == {1'b0, short_lim});
  assign long_lv  = (gap >= long_lim);

  assign bkt_inc = short_ev;
  assign bkt_dec = gate_end && (bucket != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bucket <= '0;
    else if (bkt_inc && !bkt_dec && bucket != '1) bucket <= bucket + BKT_W'(1);
    else if (bkt_dec && !bkt_inc)                 bucket <= bucket - BKT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_dirty <= 1'b0;
    else if (gate_end)             win_dirty <= 1'b0;
    else if (short_ev || long_lv)  win_dirty <= 1'b1;
  end

  assign act_alarm = long_lv | (bucket >= bucket_thr);
  assign act_clean = !(win_dirty | short_ev | long_lv);
endmodule

// File: rtl/refsel_freq.sv
// Per-input frequency monitor: edges counted over the shared gate window.
module refsel_freq #(
  parameter int GATE_LEN  = 4096,
  parameter int NOM_EDGES = 256,
  parameter int TOL_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_p,
  input  logic gate_end,
  output logic in_range,
  output logic freq_bad
);
  localparam int             CNT_W = $clog2(GATE_LEN + 1);
  localparam logic [CNT_W:0] LO    = (CNT_W+1)'(NOM_EDGES - TOL_EDGES);
  localparam logic [CNT_W:0] HI    = (CNT_W+1)'(NOM_EDGES + TOL_EDGES);

  logic [CNT_W-1:0] ecnt;
  logic [CNT_W:0]   total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ecnt <= '0;
    else if (gate_end)               ecnt <= '0;
    else if (edge_p && ecnt != '1)   ecnt <= ecnt + CNT_W'(1);
  end

  assign total    = {1'b0, ecnt} + {{CNT_W{1'b0}}, edge_p};
  assign in_range = (total >= LO) && (total <= HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        freq_bad <= 1'b0;
    else if (gate_end) freq_bad <= !in_range;
  end
endmodule

// File: rtl/refsel_health.sv
// Per-input serviceability: immediate failure, restoration after a run of
// clean gate windows.
module refsel_health #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_end,
  input  logic             act_alarm,
  input  logic             act_clean,
  input  logic             in_range,
  input  logic             freq_bad,
  input  logic             freq_en,
  input  logic [WIN_W-1:0] restore_wins,
  output logic             failed
);
  logic [WIN_W-1:0] good_run;
  logic [WIN_W:0]   run_next;
  logic             fail_now, win_good;

  assign fail_now = act_alarm || (freq_en && freq_bad);
  assign win_good = act_clean && (!freq_en || in_range);
  assign run_next = {1'b0, good_run} + (WIN_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failed   <= 1'b1;
      good_run <= '0;
    end else if (fail_now) begin
      failed   <= 1'b1;
      good_run <= '0;
    end else if (failed && gate_end) begin
      if (!win_good) begin
        good_run <= '0;
      end else if (run_next >= {1'b0, restore_wins}) begin
        failed   <= 1'b0;
        good_run <= '0;
      end else begin
        good_run <= run_next[WIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/refsel_pick.sv
// Priority pick: smallest nonzero priority among available inputs,
// lower index first on a tie.
module refsel_pick #(
  parameter int NUM_REF = 4,
  parameter int PRI_W   = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_REF-1:0]       avail,
  input  logic [NUM_REF*PRI_W-1:0] pri,
  output logic                     found,
  output logic [IDX_W-1:0]         idx
);
  logic [PRI_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_REF; i++) begin
      if (avail[i] && pri[i*PRI_W +: PRI_W] != '0 &&
          (!found || pri[i*PRI_W +: PRI_W] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = pri[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
  import refsel_pkg::*;
#(
  parameter int GATE_LEN  = 4096,
  parameter int NOM_EDGES = 256,
  parameter int TOL_EDGES = 4,
  parameter int PRI_W     = 4,
  parameter int GAP_W     = 16,
  parameter int BKT_W     = 4,
  parameter int WIN_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [REF_COUNT-1:0]       ref_in,
  input  logic [REF_COUNT*PRI_W-1:0] ref_pri,
  input  logic                       freq_chk_en,
  input  logic [GAP_W-1:0]           short_lim,
  input  logic [GAP_W-1:0]           long_lim,
  input  logic [BKT_W-1:0]           bucket_thr,
  input  logic [WIN_W-1:0]           restore_wins,
  output logic [REF_IDX_W-1:0]       sel_idx,
  output logic                       sel_valid,
  output logic                       switch_pulse,
  output logic [REF_COUNT-1:0]       ref_ok,
  output logic [REF_COUNT-1:0]       ref_gap_alarm,
  output logic [REF_COUNT-1:0]       ref_freq_alarm
);
  localparam int GCNT_W = (GATE_LEN > 1) ? $clog2(GATE_LEN) : 1;
  localparam logic [GCNT_W-1:0] GATE_LAST = GCNT_W'(GATE_LEN - 1);

  logic [GCNT_W-1:0]    gcnt;
  logic                 gate_end;
  logic [REF_COUNT-1:0] edge_v, act_alarm_v, act_clean_v;
  logic [REF_COUNT-1:0] in_range_v, freq_bad_v, failed_v;
  logic                 pick_found;
  logic [REF_IDX_W-1:0] pick_idx;
  pick_t                sel_q;

  // shared gate window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gcnt <= '0;
    else if (gate_end) gcnt <= '0;
    else               gcnt <= gcnt + GCNT_W'(1);
  end
  assign gate_end = (gcnt == GATE_LAST);

  for (genvar i = 0; i < REF_COUNT; i++) begin : g_ref
    refsel_lane #(.GAP_W(GAP_W), .BKT_W(BKT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_raw    (ref_in[i]),
      .gate_end   (gate_end),
      .short_lim  (short_lim),
      .long_lim   (long_lim),
      .bucket_thr (bucket_thr),
      .edge_p     (edge_v[i]),
      .act_alarm  (act_alarm_v[i]),
      .act_clean  (act_clean_v[i])
    );

    refsel_freq #(
      .GATE_LEN  (GATE_LEN),
      .NOM_EDGES (NOM_EDGES),
      .TOL_EDGES (TOL_EDGES)
    ) u_freq (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_p   (edge_v[i]),
      .gate_end (gate_end),
      .in_range (in_range_v[i]),
      .freq_bad (freq_bad_v[i])
    );

    refsel_health #(.WIN_W(WIN_W)) u_health (
      .clk          (clk),
      .rst_n        (rst_n),
      .gate_end     (gate_end),
      .act_alarm    (act_alarm_v[i]),
      .act_clean    (act_clean_v[i]),
      .in_range     (in_range_v[i]),
      .freq_bad     (freq_bad_v[i]),
      .freq_en      (freq_chk_en),
      .restore_wins (restore_wins),
      .failed       (failed_v[i])
    );
  end

  refsel_pick #(.NUM_REF(REF_COUNT), .PRI_W(PRI_W), .IDX_W(REF_IDX_W)) u_pick (
    .avail (~failed_v),
    .pri   (ref_pri),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= '0;
      switch_pulse <= 1'b0;
    end else begin
      sel_q.valid  <= pick_found;
      sel_q.idx    <= pick_idx;
      switch_pulse <= (pick_found != sel_q.valid) ||
                      (pick_found && pick_idx != sel_q.idx);
    end
  end

  assign sel_idx        = sel_q.idx;
  assign sel_valid      = sel_q.valid;
  assign ref_ok         = ~failed_v;
  assign ref_gap_alarm  = act_alarm_v;
  assign ref_freq_alarm = freq_bad_v;
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker #(
  parameter int NUM_REF = 4,
  parameter int PRI_W   = 4,
  parameter int IDX_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       gate_end,
  input logic                       freq_chk_en,
  input logic [NUM_REF*PRI_W-1:0]   ref_pri,
  input logic [IDX_W-1:0]           sel_idx,
  input logic                       sel_valid,
  input logic                       switch_pulse,
  input logic [NUM_REF-1:0]         ref_ok,
  input logic [NUM_REF-1:0]         ref_gap_alarm,
  input logic [NUM_REF-1:0]         ref_freq_alarm
);
  logic [NUM_REF-1:0]       ok_q;
  logic [NUM_REF*PRI_W-1:0] pri_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= '0;
      pri_q <= '0;
    end else begin
      ok_q  <= ref_ok;
      pri_q <= ref_pri;
    end
  end

  for (genvar i = 0; i < NUM_REF; i++) begin : g_chk
    assert_gap_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gap_alarm[i] |=> !ref_ok[i]);
    assert_freq_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_chk_en && ref_freq_alarm[i]) |=> !ref_ok[i]);
    assert_restore_at_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_ok[i]) |-> $past(gate_end));
  end

  assert_sel_serviceable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ok_q[sel_idx]);
  assert_sel_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (pri_q[sel_idx*PRI_W +: PRI_W] != '0));
  assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (sel_valid != $past(sel_valid) || sel_idx != $past(sel_idx)));
  assert_quiet_when_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_pulse |-> ($stable(sel_valid) && $stable(sel_idx)));
endmodule

bind refclk_selector refsel_checker #(
  .NUM_REF (refsel_pkg::REF_COUNT),
  .PRI_W   (PRI_W),
  .IDX_W   (refsel_pkg::REF_IDX_W)
) u_refsel_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .gate_end       (gate_end),
  .freq_chk_en    (freq_chk_en),
  .ref_pri        (ref_pri),
  .sel_idx        (sel_idx),
  .sel_valid      (sel_valid),
  .switch_pulse   (switch_pulse),
  .ref_ok         (ref_ok),
  .ref_gap_alarm  (ref_gap_alarm),
  .ref_freq_alarm (ref_freq_alarm)
);

// File: tb/refclk_selector_bench.sv
module refclk_selector_bench;
  localparam int GL  = 64;
  localparam int NOM = 8;
  localparam int TOL = 2;
  localparam int PW  = 4;
  localparam int GW  = 16;
  localparam int BW  = 4;
  localparam int WW  = 4;
  localparam int N   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [N-1:0]     ref_r = '0;
  logic [N*PW-1:0]  pri   = '0;
  logic             fen   = 1'b1;
  logic [GW-1:0]    slim  = 16'd12;
  logic [GW-1:0]    llim  = 16'd40;
  logic [BW-1:0]    thr   = 4'd2;
  logic [WW-1:0]    rwin  = 4'd2;
  logic [1:0]       sel_idx;
  logic             sel_valid, sw;
  logic [N-1:0]     ok, galm, falm;

  refclk_selector #(
    .GATE_LEN(GL), .NOM_EDGES(NOM), .TOL_EDGES(TOL),
    .PRI_W(PW), .GAP_W(GW), .BKT_W(BW), .WIN_W(WW)
  ) u_refclk_selector (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_r), .ref_pri(pri),
    .freq_chk_en(fen), .short_lim(slim), .long_lim(llim),
    .bucket_thr(thr), .restore_wins(rwin),
    .sel_idx(sel_idx), .sel_valid(sel_valid), .switch_pulse(sw),
    .ref_ok(ok), .ref_gap_alarm(galm), .ref_freq_alarm(falm)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sw_seen = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // reference clock generators (half period in clk cycles, freeze window)
  int half[N]       = '{4, 4, 4, 4};
  int hold_until[N] = '{0, 0, 0, 0};
  int ph[N]         = '{0, 1, 2, 3};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (cyc >= hold_until[i]) begin
        ph[i]++;
        if (ph[i] >= half[i]) begin
          ph[i] = 0;
          ref_r[i] = ~ref_r[i];
        end
      end
    end
  end

  // behavioural reference model, advanced on every rising edge
  int m_s1[N], m_s2[N], m_s3[N], m_gap[N], m_bkt[N], m_dirty[N];
  int m_ecnt[N], m_fbad[N], m_fail[N], m_run[N];
  int m_gcnt, m_sv, m_si, m_sw;

  always @(posedge clk) begin
    int ge, bv, bi, bp, p, ed, sev, llv, alarm, clean, total, inr, good, fnow;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_gap[i] = 0; m_bkt[i] = 0;
        m_dirty[i] = 0; m_ecnt[i] = 0; m_fbad[i] = 0; m_fail[i] = 1; m_run[i] = 0;
      end
      m_gcnt = 0; m_sv = 0; m_si = 0; m_sw = 0;
    end else begin
      ge = (m_gcnt == GL - 1);
      bv = 0; bi = 0; bp = 0;
      for (int i = 0; i < N; i++) begin
        p = int'(pri[i*PW +: PW]);
        if (m_fail[i] == 0 && p != 0 && (bv == 0 || p < bp)) begin
          bv = 1; bi = i; bp = p;
        end
      end
      m_sw = (bv != m_sv) || (bv == 1 && bi != m_si);
      m_sv = bv;
      m_si = bi;
      for (int i = 0; i < N; i++) begin
        ed    = (m_s2[i] == 1 && m_s3[i] == 0);
        sev   = !ed && (m_gap[i] + 1 == int'(slim));
        llv   = (m_gap[i] >= int'(llim));
        alarm = llv || (m_bkt[i] >= int'(thr));
        clean = !(m_dirty[i] != 0 || sev || llv);
        total = m_ecnt[i] + ed;
        inr   = (total >= NOM - TOL) && (total <= NOM + TOL);
        good  = clean && (!fen || inr);
        fnow  = alarm || (fen && m_fbad[i] != 0);
        if (fnow) begin
          m_fail[i] = 1; m_run[i] = 0;
        end else if (m_fail[i] != 0 && ge) begin
          if (!good) m_run[i] = 0;
          else if (m_run[i] + 1 >= int'(rwin)) begin m_fail[i] = 0; m_run[i] = 0; end
          else m_run[i] = m_run[i] + 1;
        end
        if (ge) m_fbad[i] = !inr;
        if (ge) m_ecnt[i] = 0; else if (ed) m_ecnt[i]++;
        if (ge) m_dirty[i] = 0; else if (sev || llv) m_dirty[i] = 1;
        if (sev && !(ge && m_bkt[i] != 0) && m_bkt[i] != 15) m_bkt[i]++;
        else if ((ge && m_bkt[i] != 0) && !sev) m_bkt[i]--;
        if (ed) m_gap[i] = 0; else if (m_gap[i] != 65535) m_gap[i]++;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = int'(ref_r[i]);
      end
      m_gcnt = ge ? 0 : m_gcnt + 1;
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    int eok, eg, ef;
    if (rst_n && !done) begin
      eok = 0; eg = 0; ef = 0;
      for (int i = 0; i < N; i++) begin
        if (m_fail[i] == 0) eok |= (1 << i);
        if (m_gap[i] >= int'(llim) || m_bkt[i] >= int'(thr)) eg |= (1 << i);
        if (m_fbad[i] != 0) ef |= (1 << i);
      end
      chk("R9 model switch_pulse", int'(sw), m_sw);
      chk("R8 model sel_valid", int'(sel_valid), m_sv);
      chk("R8 model sel_idx", int'(sel_idx), m_si);
      chk("R10 model ref_ok", int'(ok), eok);
      chk("R7 model ref_gap_alarm", int'(galm), eg);
      chk("R3 model ref_freq_alarm", int'(falm), ef);
      if (sw) sw_seen++;
    end
  end

  always @(posedge clk) begin
    if (cyc >= 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog at cycle %0d: actual=running expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic freeze(int i, int n);
    hold_until[i] = cyc + n;
  endtask

  initial begin
    int base;
    pri = {4'd0, 4'd3, 4'd1, 4'd2};
    wait_n(4);
    chk("R1 reset ref_ok", int'(ok), 0);
    chk("R1 reset sel_valid", int'(sel_valid), 0);
    chk("R1 reset switch_pulse", int'(sw), 0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 after reset ref_ok", int'(ok), 0);

    wait_n(400);
    chk("R2 all restored", int'(ok), 15);
    chk("R8 best priority valid", int'(sel_valid), 1);
    chk("R8 best priority index", int'(sel_idx), 1);

    freeze(1, 6);
    wait_n(200);
    chk("R5 single short gap keeps ref_ok", int'(ok[1]), 1);
    chk("R5 single short gap keeps selection", int'(sel_idx), 1);

    base = sw_seen;
    freeze(1, 6); wait_n(16);
    freeze(1, 6); wait_n(16);
    freeze(1, 6); wait_n(80);
    chk("R7 burst of short gaps fails", int'(ok[1]), 0);
    chk("R10 failed input not selected", int'(sel_idx), 0);
    chk("R9 one switch on failure", sw_seen - base, 1);

    wait_n(600);
    chk("R10 restored input reselected", int'(sel_idx), 1);
    chk("R2 restored after clean windows", int'(ok[1]), 1);

    freeze(0, 50);
    wait_n(47);
    chk("R6 long gap alarm", int'(galm[0]), 1);
    chk("R6 long gap fails", int'(ok[0]), 0);
    wait_n(400);

    half[2] = 2;
    wait_n(200);
    chk("R3 frequency alarm", int'(falm[2]), 1);
    chk("R3 frequency failure", int'(ok[2]), 0);

    fen = 1'b0;
    wait_n(300);
    chk("R4 restored with check off", int'(ok[2]), 1);
    chk("R4 raw alarm still reported", int'(falm[2]), 1);

    half[2] = 4;
    fen = 1'b1;
    wait_n(300);
    chk("R2 all serviceable again", int'(ok), 15);

    pri = {4'd2, 4'd2, 4'd2, 4'd2};
    wait_n(3);
    chk("R8 tie goes to lowest index", int'(sel_idx), 0);
    pri = {4'd2, 4'd2, 4'd2, 4'd0};
    wait_n(3);
    chk("R8 zero priority disables", int'(sel_idx), 1);
    pri = '0;
    wait_n(3);
    chk("R8 none enabled gives invalid", int'(sel_valid), 0);
    chk("R8 none enabled gives index 0", int'(sel_idx), 0);

    wait_n(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule